// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry

This block shifts or rotates a 32-bit value by an amount taken from a register operand and produces the result together with an updated carry flag. It supports four operations: logical left, logical right, arithmetic right and rotate right. Only the low byte of the amount operand counts, so every amount from 0 to 255 has a defined result and carry. That includes the awkward ones: zero, exactly the data width, more than the width, and rotates by whole multiples of the width.

The shift itself is combinational. A thin registered stage captures the result and carry whenever the valid strobe is high at a clock edge, and flags the captured pair with an output valid for one cycle. An integer pipeline would place it where a register-specified shift feeds the ALU's second operand and the flag logic.

Top module: `regshift_unit`

## Requirements
- R1: Only bits [7:0] of `in_amount` select the amount. Bits [31:8] never change the result or the carry.
- R2: An amount of zero, for any kind, gives a result equal to `in_value` and a carry equal to `in_carry`.
- R3: Kind 2'b00 (logical left) with amount n in 1..31 gives `in_value << n` with zeros filled in, and a carry equal to `in_value[32-n]`.
- R4: Logical left by exactly 32 gives result 0 with carry `in_value[0]`. Logical left by 33..255 gives result 0 with carry 0.
- R5: Kind 2'b01 (logical right) with n in 1..31 gives `in_value >> n` with zeros filled in, and a carry equal to `in_value[n-1]`.
- R6: Logical right by exactly 32 gives result 0 with carry `in_value[31]`. Logical right by 33..255 gives result 0 with carry 0.
- R7: Kind 2'b10 (arithmetic right) with n in 1..31 fills the vacated bits with `in_value[31]` and gives a carry equal to `in_value[n-1]`.
- R8: Arithmetic right by 32..255 gives a result with every bit equal to `in_value[31]`, and a carry equal to `in_value[31]`.
- R9: Kind 2'b11 (rotate right) rotates by the amount modulo 32. When that remainder m is nonzero, the carry equals `in_value[m-1]`.
- R10: A rotate whose amount is a nonzero multiple of 32 (32, 64, ..., 224) returns `in_value` unchanged with a carry equal to `in_value[31]`.
- R11: When `in_valid` is high at a rising edge, `out_result` and `out_carry` show that operation from that edge on, and `out_valid` is high for that cycle. When `in_valid` is low at an edge, `out_valid` goes low and `out_result` and `out_carry` hold their values.
- R12: A synchronous active-high `rst` clears `out_valid`, `out_result` and `out_carry` to 0, and it takes priority over `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for the current operation |
| in_value | input | 32 | Value to be shifted |
| in_amount | input | 32 | Amount operand; only the low byte is used |
| in_kind | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | High for one cycle after a capture |
| out_result | output | 32 | Registered shifted value |
| out_carry | output | 1 | Registered new carry flag |

## Verification
The bench runs every one of the 256 amounts for each kind. It uses random values and patterns that separate the ends of the word (all zeros, all ones, only the sign bit, only bit 0), with both carry-in values, and with random junk in the upper amount bits. Each corner has its own typical failure:
- A design that treats an amount of exactly 32 like a larger one loses the carry from bit 0 or bit 31.
- A design that takes the amount modulo 32 for the plain shifts returns the unshifted value at 32, 64 and so on.
- A rotate that does not special-case multiples of 32 leaves the carry unchanged instead of copying the sign bit.
- A zero amount that is not handled apart picks a carry from an out-of-range bit instead of passing the incoming flag through.

The bench also checks that an idle strobe holds the outputs and that reset wins over a simultaneous strobe.

// File: rtl/regshift_pkg.sv
package regshift_pkg;

    localparam int DATA_W = 32;
    localparam int AMT_W  = 8;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    // Classification of the amount byte against the data width
    typedef struct packed {
        logic zero;      // whole amount is zero
        logic below;     // amount lies in 1..width-1 (or zero)
        logic exact;     // amount equals width
        logic idx_zero;  // amount modulo width is zero
    } amt_class_t;

    function automatic logic is_right_kind(shift_kind_e k);
        return (k == SK_LSR) || (k == SK_ASR);
    endfunction

endpackage

// File: rtl/regshift_decode.sv
module regshift_decode #(
    parameter int DATA_W = regshift_pkg::DATA_W,
    parameter int AMT_W  = regshift_pkg::AMT_W
) (
    input  logic [AMT_W-1:0]        amt,
    output regshift_pkg::amt_class_t cls
);
    localparam int SH_W = $clog2(DATA_W);
    localparam logic [AMT_W:0] WIDTH_VAL = (AMT_W+1)'(DATA_W);

    logic [AMT_W:0] amt_ext;

    always_comb begin
        amt_ext      = {1'b0, amt};
        cls.zero     = (amt == '0);
        cls.below    = (amt_ext < WIDTH_VAL);
        cls.exact    = (amt_ext == WIDTH_VAL);
        cls.idx_zero = (amt[SH_W-1:0] == '0);
    end

endmodule

// File: rtl/regshift_barrel.sv
module regshift_barrel #(
    parameter int W = regshift_pkg::DATA_W
) (
    input  logic [W-1:0]          din,
    input  logic [$clog2(W)-1:0]  n,
    input  logic                  rotate,
    input  logic                  fill,
    output logic [W-1:0]          dout
);
    localparam int SH_W = $clog2(W);

    logic [W-1:0] stage [0:SH_W];

    assign stage[0] = din;

    // One mux level per amount bit; each level moves by a power of two
    for (genvar i = 0; i < SH_W; i++) begin : g_level
        localparam int S = 1 << i;
        logic [W-1:0] moved;
        always_comb begin
            if (rotate)
                moved = {stage[i][S-1:0], stage[i][W-1:S]};
            else
                moved = {{S{fill}}, stage[i][W-1:S]};
        end
        assign stage[i+1] = n[i] ? moved : stage[i];
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/regshift_core.sv
module regshift_core #(
    parameter int DATA_W = regshift_pkg::DATA_W,
    parameter int AMT_W  = regshift_pkg::AMT_W
) (
    input  logic [DATA_W-1:0]        data,
    input  logic [AMT_W-1:0]         amt,
    input  regshift_pkg::shift_kind_e kind,
    input  logic                     cin,
    output logic [DATA_W-1:0]        result,
    output logic                     cout
);
    import regshift_pkg::*;

    localparam int SH_W = $clog2(DATA_W);

    amt_class_t        cls;
    logic [DATA_W-1:0] data_rev;
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] shifted_rev;
    logic [DATA_W-1:0] core_out;
    logic [SH_W-1:0]   n;
    logic [SH_W-1:0]   n_m1;
    logic              fill;
    logic              rot;
    logic              last_out;

    regshift_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_decode (
        .amt (amt),
        .cls (cls)
    );

    // Left shifts reuse the right-shifting barrel on a mirrored word
    assign data_rev = {<<{data}};
    assign src      = (kind == SK_LSL) ? data_rev : data;
    assign n        = amt[SH_W-1:0];
    assign n_m1     = n - 1'b1;
    assign rot      = (kind == SK_ROR);
    assign fill     = (kind == SK_ASR) & data[DATA_W-1];
    assign last_out = src[n_m1];

    regshift_barrel #(.W(DATA_W)) u_barrel (
        .din    (src),
        .n      (n),
        .rotate (rot),
        .fill   (fill),
        .dout   (shifted)
    );

    assign shifted_rev = {<<{shifted}};
    assign core_out    = (kind == SK_LSL) ? shifted_rev : shifted;

    always_comb begin
        result = data;
        cout   = cin;
        if (cls.zero) begin
            result = data;
            cout   = cin;
        end else if (rot) begin
            if (cls.idx_zero) begin
                result = data;
                cout   = data[DATA_W-1];
            end else begin
                result = core_out;
                cout   = last_out;
            end
        end else if (cls.below) begin
            result = core_out;
            cout   = last_out;
        end else begin
            result = {DATA_W{fill}};
            if (cls.exact)
                cout = src[DATA_W-1];
            else
                cout = (kind == SK_ASR) & data[DATA_W-1];
        end
    end

endmodule

// File: rtl/regshift_unit.sv
module regshift_unit #(
    parameter int DATA_W = regshift_pkg::DATA_W,
    parameter int AMT_W  = regshift_pkg::AMT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_value,
    input  logic [DATA_W-1:0] in_amount,
    input  logic [1:0]        in_kind,
    input  logic              in_carry,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_carry
);
    import regshift_pkg::*;

    localparam logic [AMT_W:0] WIDTH_VAL = (AMT_W+1)'(DATA_W);

    logic [DATA_W-1:0] comb_result;
    logic              comb_carry;
    logic              amt_hi_unused;
    shift_kind_e       kind;

    assign kind          = shift_kind_e'(in_kind);
    assign amt_hi_unused = ^in_amount[DATA_W-1:AMT_W];

    regshift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .data   (in_value),
        .amt    (in_amount[AMT_W-1:0]),
        .kind   (kind),
        .cin    (in_carry),
        .result (comb_result),
        .cout   (comb_carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_carry  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= comb_result;
                out_carry  <= comb_carry;
            end
        end
    end

    assert_zero_passthrough_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_amount[AMT_W-1:0] == '0)
        |=> (out_result == $past(in_value) && out_carry == $past(in_carry)));

    assert_lsl_over_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 2'b00 && {1'b0, in_amount[AMT_W-1:0]} > WIDTH_VAL)
        |=> (out_result == '0 && !out_carry));

    assert_asr_saturate_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 2'b10 && {1'b0, in_amount[AMT_W-1:0]} >= WIDTH_VAL)
        |=> (out_result == {DATA_W{$past(in_value[DATA_W-1])}}
             && out_carry == $past(in_value[DATA_W-1])));

    assert_ror_multiple_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 2'b11 && in_amount[AMT_W-1:0] != '0
         && in_amount[$clog2(DATA_W)-1:0] == '0)
        |=> (out_result == $past(in_value) && out_carry == $past(in_value[DATA_W-1])));

    assert_capture_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_carry)));

endmodule

// File: tb/regshift_unit_tb.sv
module regshift_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_value;
    logic [31:0] in_amount;
    logic [1:0]  in_kind;
    logic        in_carry;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_carry;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    regshift_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_value   (in_value),
        .in_amount  (in_amount),
        .in_kind    (in_kind),
        .in_carry   (in_carry),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_carry  (out_carry)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural model written from the requirement list
    task automatic model(input logic [31:0] v, input int a, input int k, input bit ci,
                         output logic [31:0] r, output bit co);
        int m;
        r = v; co = ci;
        if (a == 0) return;
        case (k)
            0: begin
                if (a < 32)       begin r = v << a; co = v[32-a]; end
                else if (a == 32) begin r = 0; co = v[0]; end
                else              begin r = 0; co = 0; end
            end
            1: begin
                if (a < 32)       begin r = v >> a; co = v[a-1]; end
                else if (a == 32) begin r = 0; co = v[31]; end
                else              begin r = 0; co = 0; end
            end
            2: begin
                if (a < 32) begin r = $unsigned($signed(v) >>> a); co = v[a-1]; end
                else        begin r = {32{v[31]}}; co = v[31]; end
            end
            default: begin
                m = a % 32;
                if (m == 0) begin r = v; co = v[31]; end
                else begin r = (v >> m) | (v << (32 - m)); co = v[m-1]; end
            end
        endcase
    endtask

    function automatic string tag_of(input int a, input int k);
        if (a == 0) return "R2";
        case (k)
            0: return (a < 32) ? "R3" : "R4";
            1: return (a < 32) ? "R5" : "R6";
            2: return (a < 32) ? "R7" : "R8";
            default: return (a % 32 == 0) ? "R10" : "R9";
        endcase
    endfunction

    logic [31:0] last_r;
    bit          last_c;

    // Called at a falling edge; result checked at the next falling edge
    task automatic apply(input logic [31:0] v, input logic [31:0] amt_op, input int k,
                         input bit ci, input string tag_in);
        logic [31:0] er;
        bit          ec;
        string       tag;
        int          a;
        a   = int'(amt_op[7:0]);
        tag = (tag_in == "") ? tag_of(a, k) : tag_in;
        model(v, a, k, ci, er, ec);
        in_valid  = 1'b1;
        in_value  = v;
        in_amount = amt_op;
        in_kind   = 2'(k);
        in_carry  = ci;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R11 valid", {31'd0, out_valid}, 32'd1);
        check(out_result === er, {tag, " result"}, out_result, er);
        check(out_carry === ec, {tag, " carry"}, {31'd0, out_carry}, {31'd0, ec});
        last_r = er;
        last_c = ec;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] corner [0:5];
        rst = 1'b1; in_valid = 1'b0; in_value = '0; in_amount = '0;
        in_kind = 2'b00; in_carry = 1'b0;
        corner[0] = 32'h0000_0000;
        corner[1] = 32'hFFFF_FFFF;
        corner[2] = 32'h8000_0000;
        corner[3] = 32'h0000_0001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R12 valid", {31'd0, out_valid}, 32'd0);
        check(out_result === 32'd0, "R12 result", out_result, 32'd0);
        check(out_carry === 1'b0, "R12 carry", {31'd0, out_carry}, 32'd0);
        // reset wins over a strobe
        in_valid = 1'b1; in_value = 32'hDEAD_BEEF; in_amount = 32'd0; in_carry = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R12 priority valid", {31'd0, out_valid}, 32'd0);
        check(out_result === 32'd0, "R12 priority result", out_result, 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // R1: junk in upper amount bits must not matter
        apply(32'h1234_5678, 32'hFFFF_FF04, 0, 1'b0, "R1");
        apply(32'h8765_4321, 32'hABCD_EF00, 1, 1'b1, "R1");
        apply(32'hF000_000F, 32'h0000_0120, 2, 1'b0, "R1");
        apply(32'hC001_CAFE, 32'h7777_7740, 3, 1'b0, "R1");

        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 256; a++) begin
                corner[4] = $urandom;
                corner[5] = $urandom;
                for (int vi = 0; vi < 6; vi++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        apply(corner[vi], ($urandom & 32'hFFFF_FF00) | 32'(a), k,
                              ci[0], "");
                    end
                end
            end
        end

        // R11: idle strobe holds outputs while inputs change
        in_value = 32'h5A5A_5A5A; in_amount = 32'd3; in_kind = 2'b01; in_carry = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R11 idle valid", {31'd0, out_valid}, 32'd0);
        check(out_result === last_r, "R11 hold result", out_result, last_r);
        check(out_carry === last_c, "R11 hold carry", {31'd0, out_carry}, {31'd0, last_c});

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule